// File: doc/BRIEF.md
# Tag-Indexed Stride Prefetcher

This block sits beside the cache of a pipelined accelerator and watches the memory requests that the accelerator sends to that cache. Each request carries a small static tag that names the load operation in the datapath that produced it. The tag plays the role a program counter plays in a processor. Accesses from several loads of one pipelined loop arrive interleaved. The block separates them into one local stream per tag and learns a byte stride for each stream.

Once a stream has shown the same nonzero stride twice in a row, the block asks the cache to prefetch an address a configurable number of strides ahead. The cache then fills that line into itself. A stream with data-dependent addresses never builds confidence, so it never triggers a prefetch.

The block never holds up the requests it watches. There is a single output request register. When the cache is not ready, a newer prefetch replaces the one that is waiting, and the older one is lost.

Top module: `tag_stride_prefetch`

## Requirements
- R1: After reset `pf_valid` is low and every tag is untrained. The first observation of a tag after reset only records its address and never produces a prefetch.
- R2: Training state is kept separately for each of the 2^TAG_W tags. Observations of one tag do not change the stride, confidence or last address held for any other tag.
- R3: For each tag the stride is the current address minus the previous address of that tag, modulo 2^ADDR_W. A 2-bit confidence counter increments, saturating at 3, when the new stride equals the stored stride. A prefetch is produced only when the updated confidence is 2 or 3. For a constant nonzero stride, the first prefetch therefore comes on the fourth observation.
- R4: The prefetch address is the observed address plus stride × DIST, modulo 2^ADDR_W, with DIST = 2 by default. Negative strides are included. The request appears on `pf_valid`/`pf_addr` in the cycle after the edge that samples the observation.
- R5: A stride that differs from the stored stride sets the confidence to 0 and stores the new stride. Two further matching strides are then needed before the next prefetch.
- R6: A cache line is the address shifted right by LINE_W bits, which gives 64-byte lines by default. A prefetch whose line equals the line of the last prefetch produced for the same tag is suppressed.
- R7: A stride of zero never produces a prefetch.
- R8: While `pf_valid` is high and `pf_ready` is low, the request holds its address. A new prefetch overwrites it, and the old one is dropped. After an accepted request with no new prefetch, `pf_valid` falls in the next cycle.
- R9: A cycle with `obs_valid` low changes no training state and produces no new prefetch, whatever `obs_tag` and `obs_addr` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obs_valid | input | 1 | An accelerator memory request is present this cycle |
| obs_tag | input | TAG_W | Static tag of the load that issued the request |
| obs_addr | input | ADDR_W | Byte address of the request |
| pf_valid | output | 1 | A prefetch request is offered to the cache |
| pf_ready | input | 1 | The cache accepts the offered prefetch |
| pf_addr | output | ADDR_W | Byte address to prefetch |

## Verification
The hardest case to reach is a trained stream whose next target falls in the line it has just prefetched. To reach it, the stimulus needs a stride small against the line size, run for several steps after confidence saturates. A stream with a 16-byte stride is walked across a line boundary. This shows two suppressed prefetches, followed by an issued one once the target enters a new line. The training streams are interleaved over several tags. Irregular, negative-stride and zero-stride streams sit between them, so per-tag separation and the confidence reset are exercised together. Directed tests then hold `pf_ready` low to show holding and overwrite, and they put idle cycles with garbage addresses in the middle of a training run.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef logic [1:0] conf_t;
  localparam conf_t CONF_MAX  = 2'd3;
  localparam conf_t CONF_FIRE = 2'd2;

  function automatic conf_t conf_bump(input conf_t c);
    return (c == CONF_MAX) ? CONF_MAX : c + 2'd1;
  endfunction
endpackage

// File: rtl/tsp_table.sv
module tsp_table
  import tsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3,
  parameter int LINE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAG_W-1:0]         tag,
  output logic                     rd_trained,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [ADDR_W-1:0]        rd_stride,
  output conf_t                    rd_conf,
  output logic                     rd_pf_seen,
  output logic [ADDR_W-LINE_W-1:0] rd_pf_line,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [ADDR_W-1:0]        wr_stride,
  input  conf_t                    wr_conf,
  input  logic                     wr_pf_seen,
  input  logic [ADDR_W-LINE_W-1:0] wr_pf_line
);
  localparam int ENTRIES = 1 << TAG_W;
  localparam int LINE_BITS = ADDR_W - LINE_W;

  logic [ENTRIES-1:0]   trained_q;
  logic [ENTRIES-1:0]   pf_seen_q;
  logic [ADDR_W-1:0]    addr_mem   [ENTRIES];
  logic [ADDR_W-1:0]    stride_mem [ENTRIES];
  conf_t                conf_mem   [ENTRIES];
  logic [LINE_BITS-1:0] line_mem   [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      trained_q <= '0;
      pf_seen_q <= '0;
    end else if (wr_en) begin
      trained_q[tag] <= 1'b1;
      pf_seen_q[tag] <= wr_pf_seen;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_mem[tag]   <= wr_addr;
      stride_mem[tag] <= wr_stride;
      conf_mem[tag]   <= wr_conf;
      line_mem[tag]   <= wr_pf_line;
    end
  end

  assign rd_trained = trained_q[tag];
  assign rd_pf_seen = pf_seen_q[tag];
  assign rd_addr    = addr_mem[tag];
  assign rd_stride  = stride_mem[tag];
  assign rd_conf    = conf_mem[tag];
  assign rd_pf_line = line_mem[tag];
endmodule

// File: rtl/tsp_predict.sv
module tsp_predict
  import tsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6,
  parameter int DIST   = 2
) (
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic                     trained,
  input  logic [ADDR_W-1:0]        last_addr,
  input  logic [ADDR_W-1:0]        last_stride,
  input  conf_t                    conf,
  input  logic                     pf_seen,
  input  logic [ADDR_W-LINE_W-1:0] pf_line,
  output logic [ADDR_W-1:0]        nxt_stride,
  output conf_t                    nxt_conf,
  output logic                     nxt_pf_seen,
  output logic [ADDR_W-LINE_W-1:0] nxt_pf_line,
  output logic                     cand_valid,
  output logic [ADDR_W-1:0]        cand_addr
);
  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] target;
  logic              match;
  logic              fire;
  logic              same_line;

  always_comb begin
    delta     = cur_addr - last_addr;
    target    = cur_addr + delta * ADDR_W'(DIST);
    match     = trained && (delta == last_stride);
    nxt_conf  = match ? conf_bump(conf) : '0;
    nxt_stride = trained ? delta : '0;
    fire      = match && (nxt_conf >= CONF_FIRE) && (delta != '0);
    same_line = pf_seen && (target[ADDR_W-1:LINE_W] == pf_line);
    cand_valid = fire && !same_line;
    cand_addr  = target;
    nxt_pf_seen = trained && (pf_seen || cand_valid);
    nxt_pf_line = cand_valid ? target[ADDR_W-1:LINE_W] : pf_line;
  end
endmodule

// File: rtl/tsp_issue.sv
module tsp_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (cand_valid) begin
      pf_valid <= 1'b1;
      pf_addr  <= cand_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_stride_prefetch.sv
module tag_stride_prefetch
  import tsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3,
  parameter int LINE_W = 6,
  parameter int DIST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              obs_valid,
  input  logic [TAG_W-1:0]  obs_tag,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int LINE_BITS = ADDR_W - LINE_W;

  logic                 rd_trained, rd_pf_seen;
  logic [ADDR_W-1:0]    rd_addr, rd_stride;
  conf_t                rd_conf;
  logic [LINE_BITS-1:0] rd_pf_line;
  logic [ADDR_W-1:0]    nxt_stride;
  conf_t                nxt_conf;
  logic                 nxt_pf_seen;
  logic [LINE_BITS-1:0] nxt_pf_line;
  logic                 cand_raw, cand_valid;
  logic [ADDR_W-1:0]    cand_addr;

  tsp_table #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_table (
    .clk(clk), .rst(rst), .tag(obs_tag),
    .rd_trained(rd_trained), .rd_addr(rd_addr), .rd_stride(rd_stride),
    .rd_conf(rd_conf), .rd_pf_seen(rd_pf_seen), .rd_pf_line(rd_pf_line),
    .wr_en(obs_valid), .wr_addr(obs_addr), .wr_stride(nxt_stride),
    .wr_conf(nxt_conf), .wr_pf_seen(nxt_pf_seen), .wr_pf_line(nxt_pf_line)
  );

  tsp_predict #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DIST(DIST)) u_predict (
    .cur_addr(obs_addr), .trained(rd_trained), .last_addr(rd_addr),
    .last_stride(rd_stride), .conf(rd_conf), .pf_seen(rd_pf_seen),
    .pf_line(rd_pf_line), .nxt_stride(nxt_stride), .nxt_conf(nxt_conf),
    .nxt_pf_seen(nxt_pf_seen), .nxt_pf_line(nxt_pf_line),
    .cand_valid(cand_raw), .cand_addr(cand_addr)
  );

  assign cand_valid = obs_valid && cand_raw;

  tsp_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_addr(cand_addr),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              obs_valid,
  input logic [TAG_W-1:0]  obs_tag,
  input logic [ADDR_W-1:0] obs_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  logic rst_q;
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_idle_r1: assert (!pf_valid) else $error("pf_valid high after reset");
    end
    rst_q <= rst;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !obs_valid) |=> (pf_valid && $stable(pf_addr)));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready && !obs_valid) |=> !pf_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!obs_valid && !pf_valid) |=> !pf_valid);

  p_from_obs_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_valid) |-> $past(obs_valid));

  p_tag_known_r2: assert property (@(posedge clk) disable iff (rst)
    obs_valid |-> !$isunknown(obs_tag));
endmodule

bind tag_stride_prefetch tsp_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tsp_checker (
  .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_tag(obs_tag),
  .obs_addr(obs_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/test_tag_stride_prefetch.sv
`timescale 1ns/1ps
module test_tag_stride_prefetch;
  localparam int AW = 32;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          obs_valid;
  logic [TW-1:0] obs_tag;
  logic [AW-1:0] obs_addr;
  logic          pf_valid;
  logic          pf_ready;
  logic [AW-1:0] pf_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tag_stride_prefetch #(.ADDR_W(AW), .TAG_W(TW), .LINE_W(6), .DIST(2)) i_tag_stride_prefetch (
    .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_tag(obs_tag),
    .obs_addr(obs_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [AW-1:0] addr;
    logic          ev;
    logic [AW-1:0] ea;
  } vec_t;

  localparam int NV = 36;
  // tags 0/1 interleaved (R2, R3), tag2 line crossing (R6), tag3 irregular then
  // retrained (R5), tag4 negative stride (R4), tag5 zero stride (R7)
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1000, 1'b0, 32'h0},    '{3'd1, 32'h2000, 1'b0, 32'h0},
    '{3'd0, 32'h1004, 1'b0, 32'h0},    '{3'd1, 32'h2040, 1'b0, 32'h0},
    '{3'd0, 32'h1008, 1'b0, 32'h0},    '{3'd1, 32'h2080, 1'b0, 32'h0},
    '{3'd0, 32'h100C, 1'b1, 32'h1014}, '{3'd1, 32'h20C0, 1'b1, 32'h2140},
    '{3'd0, 32'h1010, 1'b0, 32'h0},    '{3'd1, 32'h2100, 1'b1, 32'h2180},
    '{3'd0, 32'h1014, 1'b0, 32'h0},    '{3'd1, 32'h2140, 1'b1, 32'h21C0},
    '{3'd1, 32'h2200, 1'b0, 32'h0},
    '{3'd2, 32'h3000, 1'b0, 32'h0},    '{3'd2, 32'h3010, 1'b0, 32'h0},
    '{3'd2, 32'h3020, 1'b0, 32'h0},    '{3'd2, 32'h3030, 1'b1, 32'h3050},
    '{3'd2, 32'h3040, 1'b0, 32'h0},    '{3'd2, 32'h3050, 1'b0, 32'h0},
    '{3'd2, 32'h3060, 1'b1, 32'h3080},
    '{3'd3, 32'h4000, 1'b0, 32'h0},    '{3'd3, 32'h4100, 1'b0, 32'h0},
    '{3'd3, 32'h4104, 1'b0, 32'h0},    '{3'd3, 32'h5000, 1'b0, 32'h0},
    '{3'd3, 32'h4008, 1'b0, 32'h0},    '{3'd3, 32'h400C, 1'b0, 32'h0},
    '{3'd3, 32'h4010, 1'b0, 32'h0},    '{3'd3, 32'h4014, 1'b1, 32'h401C},
    '{3'd4, 32'h6000, 1'b0, 32'h0},    '{3'd4, 32'h5FF0, 1'b0, 32'h0},
    '{3'd4, 32'h5FE0, 1'b0, 32'h0},    '{3'd4, 32'h5FD0, 1'b1, 32'h5FB0},
    '{3'd5, 32'h7000, 1'b0, 32'h0},    '{3'd5, 32'h7000, 1'b0, 32'h0},
    '{3'd5, 32'h7000, 1'b0, 32'h0},    '{3'd5, 32'h7000, 1'b0, 32'h0}
  };

  task automatic check(input string req, input logic ev, input logic [AW-1:0] ea);
    n_cmp++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      n_bad++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
               req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  // drive for one edge, then sample 1 ns after it
  task automatic step(input logic v, input logic [TW-1:0] t, input logic [AW-1:0] a);
    @(negedge clk);
    obs_valid = v; obs_tag = t; obs_addr = a;
    @(posedge clk);
    #1;
    obs_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; obs_valid = 1'b0; obs_tag = '0; obs_addr = '0; pf_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VECS[i].tag, VECS[i].addr);
      check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), VECS[i].ev, VECS[i].ea);
    end

    // R1: reset forgets training of tag1
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 in reset", 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;
    step(1'b1, 3'd1, 32'h2240); check("R1 retrain a", 1'b0, 32'h0);
    step(1'b1, 3'd1, 32'h2280); check("R1 retrain b", 1'b0, 32'h0);
    step(1'b1, 3'd1, 32'h22C0); check("R1 retrain c", 1'b0, 32'h0);
    step(1'b1, 3'd1, 32'h2300); check("R1 retrain d", 1'b1, 32'h2380);

    // R9: idle cycles with garbage on tag6 do not disturb training
    step(1'b1, 3'd6, 32'h9000); check("R9 a", 1'b0, 32'h0);
    step(1'b1, 3'd6, 32'h9004); check("R9 b", 1'b0, 32'h0);
    step(1'b1, 3'd6, 32'h9008); check("R9 c", 1'b0, 32'h0);
    step(1'b0, 3'd6, 32'h000FFFF0); check("R9 idle", 1'b0, 32'h0);
    step(1'b1, 3'd6, 32'h900C); check("R9 d", 1'b1, 32'h9014);

    // R8: not ready holds, new prefetch overwrites, accept clears
    step(1'b1, 3'd7, 32'hA000);
    step(1'b1, 3'd7, 32'hA040);
    step(1'b1, 3'd7, 32'hA080);
    @(negedge clk); pf_ready = 1'b0;
    step(1'b1, 3'd7, 32'hA0C0); check("R8 offered", 1'b1, 32'hA140);
    step(1'b0, 3'd0, 32'h0);    check("R8 hold 1", 1'b1, 32'hA140);
    step(1'b0, 3'd0, 32'h0);    check("R8 hold 2", 1'b1, 32'hA140);
    step(1'b1, 3'd7, 32'hA100); check("R8 overwrite", 1'b1, 32'hA180);
    @(negedge clk); pf_ready = 1'b1;
    step(1'b0, 3'd0, 32'h0);    check("R8 cleared", 1'b0, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule